// File: doc/BRIEF.md
# Page-Table Walk and Access Check Controller

This block turns a 14-bit virtual address into a 12-bit physical address by fetching one entry from a flat page table in memory. Pages are 64 bytes. The low 6 address bits pass straight through. The upper 8 bits select one of 256 table entries, and that entry supplies a 6-bit physical frame number.

The entry also carries a present flag, a modified flag and three access rights: read, write and fetch. The block checks every request against these bits. A missing page and a rights violation are reported as two separate fault kinds. A clean write that passes the checks marks the entry modified and stores it back through the same memory port.

Only one request is in flight at a time. A caller offers a request while `req_ready` is high. The outcome is then held on the result outputs until the caller acknowledges it. The lookup buffer that normally sits in front of this block is a separate unit; every request reaching this block causes a table read.

Top module: `mmu_xlate_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `mem_rd_en` and `mem_wr_en` are 0.
- R2: A request is taken only on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` stays low from that edge until the result is acknowledged, so request inputs offered in that window have no effect.
- R3: For each request, `mem_rd_en` is high for exactly one cycle, with `mem_addr` = `ptbr` + VPN (VPN = `req_vaddr[13:6]`), taken modulo 2^12. The entry is taken from `mem_rdata` in the cycle in which `mem_rvalid` is high.
- R4: The table entry is 11 bits: bit 10 present, bit 9 modified, bit 8 read right, bit 7 write right, bit 6 fetch right, bits 5:0 the frame number.
- R5: On success, `rsp_paddr` = {frame number, `req_vaddr[5:0]`}. For example, 0x03d4 through frame 0x0d gives 0x354, and 0x0020 through frame 0x28 gives 0xa20.
- R6: If the present bit is 0, the result shows `rsp_pfault`=1, `rsp_prot_fault`=0 and `rsp_paddr`=0, whatever the rights bits are.
- R7: The access type `req_kind` is encoded as 0 read, 1 write, 2 fetch and 3 reserved. An access to a present page whose right is 0, or any reserved access, gives `rsp_prot_fault`=1, `rsp_pfault`=0 and `rsp_paddr`=0.
- R8: A successful write to an entry whose modified bit is 0 causes exactly one `mem_wr_en` pulse. The pulse goes to the same `mem_addr` as the read and carries the entry with bit 9 set, before the result appears. Reads, fetches, faulting accesses and writes to entries already marked modified cause no memory write.
- R9: While `rsp_ack` is low, `rsp_valid` stays high and the result outputs do not change. One cycle with `rsp_ack` high clears `rsp_valid` and raises `req_ready` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_vaddr | input | 14 | Virtual address |
| req_kind | input | 2 | Access type: 0 read, 1 write, 2 fetch, 3 reserved |
| ptbr | input | 12 | Base address of the page table |
| mem_rd_en | output | 1 | Table entry read strobe |
| mem_wr_en | output | 1 | Table entry write strobe |
| mem_addr | output | 12 | Table entry address |
| mem_wdata | output | 11 | Updated table entry |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 11 | Table entry read data |
| rsp_valid | output | 1 | Result available |
| rsp_paddr | output | 12 | Physical address, 0 on a fault |
| rsp_pfault | output | 1 | Page not present |
| rsp_prot_fault | output | 1 | Access right violated |
| rsp_ack | input | 1 | Result consumed |

## Verification
The worked addresses exercise frame insertion and offset pass-through on two different pages. A missing page whose rights bits are all set shows that the present check wins over the rights check.

Each access type is tried against pages that grant and refuse it. This separates the read, write and fetch rights from each other and from the reserved code. Writes to clean and already-modified pages, and reads of a clean page, tell the write-back condition apart from a write on every access. A base near the top of the address space shows the entry address wrapping.

A delayed acknowledge, with a second request held on the inputs, shows that the result is held and the extra request is ignored.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_WB,
    ST_RESP
  } walk_state_e;

  localparam int unsigned N_MGMT_BITS = 5;

endpackage

// File: rtl/mmu_pte_addr.sv
module mmu_pte_addr #(
  parameter int unsigned VPN_W  = 8,
  parameter int unsigned MEM_AW = 12
) (
  input  logic [MEM_AW-1:0] base,
  input  logic [VPN_W-1:0]  vpn,
  output logic [MEM_AW-1:0] entry_addr
);
  // one table word per virtual page; sum wraps at the memory address width
  always_comb entry_addr = base + MEM_AW'(vpn);
endmodule

// File: rtl/mmu_perm_check.sv
module mmu_perm_check
  import mmu_pkg::*;
#(
  parameter int unsigned PPN_W = 6,
  localparam int unsigned PTE_W = PPN_W + N_MGMT_BITS
) (
  input  logic [PTE_W-1:0] pte,
  input  acc_kind_e        kind,
  output logic             not_present,
  output logic             rights_bad,
  output logic             mark_dirty,
  output logic [PTE_W-1:0] pte_upd
);
  localparam int unsigned B_X = PPN_W;
  localparam int unsigned B_W = PPN_W + 1;
  localparam int unsigned B_R = PPN_W + 2;
  localparam int unsigned B_D = PPN_W + 3;
  localparam int unsigned B_V = PPN_W + 4;

  logic right_ok;

  always_comb begin
    unique case (kind)
      ACC_READ:  right_ok = pte[B_R];
      ACC_WRITE: right_ok = pte[B_W];
      ACC_FETCH: right_ok = pte[B_X];
      default:   right_ok = 1'b0;
    endcase
    not_present = !pte[B_V];
    rights_bad  = pte[B_V] && !right_ok;
    mark_dirty  = pte[B_V] && right_ok && (kind == ACC_WRITE) && !pte[B_D];
    pte_upd     = pte;
    pte_upd[B_D] = 1'b1;
  end
endmodule

// File: rtl/mmu_xlate_ctrl.sv
module mmu_xlate_ctrl
  import mmu_pkg::*;
#(
  parameter int unsigned VA_W  = 14,
  parameter int unsigned PA_W  = 12,
  parameter int unsigned OFF_W = 6,
  localparam int unsigned VPN_W = VA_W - OFF_W,
  localparam int unsigned PPN_W = PA_W - OFF_W,
  localparam int unsigned PTE_W = PPN_W + N_MGMT_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic [PA_W-1:0]  ptbr,
  output logic             mem_rd_en,
  output logic             mem_wr_en,
  output logic [PA_W-1:0]  mem_addr,
  output logic [PTE_W-1:0] mem_wdata,
  input  logic             mem_rvalid,
  input  logic [PTE_W-1:0] mem_rdata,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_pfault,
  output logic             rsp_prot_fault,
  input  logic             rsp_ack
);
  localparam int unsigned B_D = PPN_W + 3;

  walk_state_e     state;
  logic [VA_W-1:0] va_q;
  acc_kind_e       kind_q;
  logic [PA_W-1:0] entry_addr;
  logic            not_present, rights_bad, mark_dirty;
  logic [PTE_W-1:0] pte_upd;
  logic [PA_W-1:0] pa_ok;

  mmu_pte_addr #(.VPN_W(VPN_W), .MEM_AW(PA_W)) u_addr (
    .base       (ptbr),
    .vpn        (req_vaddr[VA_W-1:OFF_W]),
    .entry_addr (entry_addr)
  );

  mmu_perm_check #(.PPN_W(PPN_W)) u_chk (
    .pte         (mem_rdata),
    .kind        (kind_q),
    .not_present (not_present),
    .rights_bad  (rights_bad),
    .mark_dirty  (mark_dirty),
    .pte_upd     (pte_upd)
  );

  always_comb pa_ok = {mem_rdata[PPN_W-1:0], va_q[OFF_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      req_ready      <= 1'b1;
      va_q           <= '0;
      kind_q         <= ACC_READ;
      mem_rd_en      <= 1'b0;
      mem_wr_en      <= 1'b0;
      mem_addr       <= '0;
      mem_wdata      <= '0;
      rsp_valid      <= 1'b0;
      rsp_paddr      <= '0;
      rsp_pfault     <= 1'b0;
      rsp_prot_fault <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            va_q      <= req_vaddr;
            kind_q    <= acc_kind_e'(req_kind);
            mem_addr  <= entry_addr;
            mem_rd_en <= 1'b1;
            req_ready <= 1'b0;
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          mem_rd_en <= 1'b0;
          if (mem_rvalid) begin
            rsp_pfault     <= not_present;
            rsp_prot_fault <= rights_bad;
            rsp_paddr      <= (not_present || rights_bad) ? '0 : pa_ok;
            if (mark_dirty) begin
              mem_wr_en <= 1'b1;
              mem_wdata <= pte_upd;
              state     <= ST_WB;
            end else begin
              rsp_valid <= 1'b1;
              state     <= ST_RESP;
            end
          end
        end
        ST_WB: begin
          mem_wr_en <= 1'b0;
          rsp_valid <= 1'b1;
          state     <= ST_RESP;
        end
        ST_RESP: begin
          if (rsp_ack) begin
            rsp_valid <= 1'b0;
            req_ready <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: never idle while a result is pending
  a_r2_single_flight: assert property (@(posedge clk) disable iff (rst)
    !(req_ready && rsp_valid));

  // R3: table read strobe lasts one cycle
  a_r3_rd_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  // R5: offset passes through on success
  a_r5_offset: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_pfault && !rsp_prot_fault) |->
      rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]);

  // R6/R7: fault kinds exclusive, no address on a fault
  a_r6_fault_excl: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !(rsp_pfault && rsp_prot_fault));
  a_r7_no_pa: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_pfault || rsp_prot_fault)) |-> rsp_paddr == '0);

  // R8: write-back carries the modified bit, to the address just read
  a_r8_wb_dirty: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> (mem_wdata[B_D] && !rsp_pfault && !rsp_prot_fault && $stable(mem_addr)));

  // R9: result held until acknowledged
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ack) |=> (rsp_valid && $stable(rsp_paddr)
      && $stable(rsp_pfault) && $stable(rsp_prot_fault)));
endmodule

// File: tb/sim_mmu_xlate_ctrl.sv
module sim_mmu_xlate_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PTE_W = 11;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [13:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic [11:0] ptbr = 12'h100;
  logic mem_rd_en, mem_wr_en;
  logic [11:0] mem_addr;
  logic [PTE_W-1:0] mem_wdata;
  logic mem_rvalid = 1'b0;
  logic [PTE_W-1:0] mem_rdata = '0;
  logic rsp_valid, rsp_pfault, rsp_prot_fault;
  logic [11:0] rsp_paddr;
  logic rsp_ack = 1'b0;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [PTE_W-1:0] pt [256];
  logic [11:0] last_rd = '0, last_wr = '0;
  int rd_cnt = 0, wr_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_xlate_ctrl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_kind(req_kind), .ptbr(ptbr),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_pfault(rsp_pfault),
    .rsp_prot_fault(rsp_prot_fault), .rsp_ack(rsp_ack)
  );

  // page table memory, one-cycle read latency
  always @(posedge clk) begin
    mem_rvalid <= mem_rd_en;
    if (mem_rd_en) begin
      mem_rdata <= pt[8'(mem_addr - ptbr)];
      last_rd   <= mem_addr;
      rd_cnt    <= rd_cnt + 1;
    end
    if (mem_wr_en) begin
      pt[8'(mem_addr - ptbr)] <= mem_wdata;
      last_wr <= mem_addr;
      wr_cnt  <= wr_cnt + 1;
    end
  end

  function automatic logic [PTE_W-1:0] mk(bit v, bit d, bit r, bit w, bit x, logic [5:0] ppn);
    return {v, d, r, w, x, ppn};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic put(logic [7:0] vpn, logic [PTE_W-1:0] e);
    @(negedge clk);
    pt[vpn] <= e;
  endtask

  // offer one request, wait for its result (not acknowledged)
  task automatic issue(logic [13:0] va, logic [1:0] k);
    @(negedge clk);
    req_vaddr = va; req_kind = k; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 40 && !rsp_valid; i++) @(negedge clk);
    chk(rsp_valid, "R2 result arrives", 32'(rsp_valid), 1);
  endtask

  task automatic ack();
    rsp_ack = 1'b1;
    @(negedge clk);
    rsp_ack = 1'b0;
    chk(!rsp_valid && req_ready, "R9 ack clears result", {rsp_valid, req_ready}, 2'b01);
  endtask

  task automatic expect_res(string req, logic [11:0] pa, bit pf, bit pv);
    chk(rsp_paddr == pa, req, rsp_paddr, pa);
    chk(rsp_pfault == pf && rsp_prot_fault == pv, req, {rsp_pfault, rsp_prot_fault}, {pf, pv});
  endtask

  task automatic t_reset();
    chk(req_ready && !rsp_valid && !mem_rd_en && !mem_wr_en, "R1 reset state",
        {req_ready, rsp_valid, mem_rd_en, mem_wr_en}, 4'b1000);
  endtask

  task automatic t_examples();
    int w0, r0;
    w0 = wr_cnt; r0 = rd_cnt;
    issue(14'h03d4, 2'd0);
    chk(last_rd == 12'h10f, "R3 entry address", last_rd, 12'h10f);
    chk(rd_cnt == r0 + 1, "R3 single read", rd_cnt, r0 + 1);
    expect_res("R5 0x03d4", 12'h354, 0, 0);
    ack();
    issue(14'h0020, 2'd0);
    expect_res("R5 0x0020", 12'ha20, 0, 0);
    ack();
    issue(14'h038f, 2'd0);
    expect_res("R6 not present", 12'h000, 1, 0);
    ack();
    chk(wr_cnt == w0, "R8 no write on read/fault", wr_cnt, w0);
  endtask

  task automatic t_rights();
    int w0;
    w0 = wr_cnt;
    issue(14'h036b, 2'd2);
    expect_res("R7 fetch allowed (R4 layout)", 12'hb6b, 0, 0);
    ack();
    issue(14'h036b, 2'd1);
    expect_res("R7 write refused", 12'h000, 0, 1);
    ack();
    issue(14'h0020, 2'd2);
    expect_res("R7 fetch refused", 12'h000, 0, 1);
    ack();
    issue(14'h03d4, 2'd3);
    expect_res("R7 reserved kind", 12'h000, 0, 1);
    ack();
    issue(14'h0440, 2'd0);
    expect_res("R7 read refused", 12'h000, 0, 1);
    ack();
    chk(wr_cnt == w0, "R8 no write on fault", wr_cnt, w0);
  endtask

  task automatic t_dirty();
    int w0;
    w0 = wr_cnt;
    issue(14'h0005, 2'd1);
    expect_res("R8 clean write result", 12'ha05, 0, 0);
    chk(wr_cnt == w0 + 1, "R8 one write-back", wr_cnt, w0 + 1);
    chk(last_wr == 12'h100, "R8 write-back address", last_wr, 12'h100);
    chk(pt[0] == mk(1,1,1,1,0,6'h28), "R8 modified bit set", pt[0], mk(1,1,1,1,0,6'h28));
    ack();
    issue(14'h0006, 2'd1);
    chk(wr_cnt == w0 + 1, "R8 no write when modified", wr_cnt, w0 + 1);
    ack();
    issue(14'h0400, 2'd0);
    chk(wr_cnt == w0 + 1, "R8 no write on clean read", wr_cnt, w0 + 1);
    expect_res("R5 page 0x10", 12'h3c0, 0, 0);
    ack();
  endtask

  task automatic t_hold();
    logic [11:0] pa0;
    int r0;
    r0 = rd_cnt;
    issue(14'h03d4, 2'd0);
    pa0 = rsp_paddr;
    req_vaddr = 14'h0020; req_kind = 2'd1; req_valid = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == pa0 && !req_ready, "R9 held while unacked",
          rsp_paddr, pa0);
    end
    chk(rd_cnt == r0 + 1, "R2 busy request ignored", rd_cnt, r0 + 1);
    req_valid = 1'b0;
    ack();
  endtask

  task automatic t_wrap();
    @(negedge clk);
    ptbr = 12'hf80;
    issue(14'h2800, 2'd0);
    chk(last_rd == 12'h020, "R3 address wraps", last_rd, 12'h020);
    expect_res("R5 wrapped base", 12'h140, 0, 0);
    ack();
    ptbr = 12'h100;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) pt[i] = '0;
    pt[8'h0f] = mk(1,0,1,0,0,6'h0d);
    pt[8'h00] = mk(1,0,1,1,0,6'h28);
    pt[8'h0e] = mk(0,0,1,1,1,6'h11);
    pt[8'h0d] = mk(1,0,1,0,1,6'h2d);
    pt[8'h11] = mk(1,0,0,1,1,6'h12);
    pt[8'h10] = mk(1,0,1,1,0,6'h0f);
    pt[8'ha0] = mk(1,0,1,0,0,6'h05);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_examples();
    t_rights();
    t_dirty();
    t_hold();
    t_wrap();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule